// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block steps the control unit of a small 16-bit microcoded processor. A 6-bit state register selects one of 64 entries in a constant control store. Each entry is a 35-bit microinstruction. It carries 26 datapath control bits, a 6-bit jump target, a 2-bit condition selector and a decode flag. The sequencer drives the current microinstruction onto its outputs. It also forms the address of the next state from that microinstruction and a few status inputs: the memory-ready flag, the latched branch-enable bit and instruction bits [15:11].

The next address is not chosen by a case-statement state machine. The jump target is used as a base, and the one condition bit named by the condition selector is OR-ed into a fixed bit position of that base. When the decode flag is set, the jump target is ignored and the block dispatches on the 4-bit opcode. In parallel, the block evaluates the branch-enable value from instruction bits [11:9] and the N/Z/P condition codes, so the datapath can latch it.

Top module: `mseq_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the state register at 18, the instruction-fetch state, on the next rising edge.
- R2: `uinst` always shows the control-store entry of the current state, with the decode flag in bit 34, the condition selector in bits 33:32, the jump target in bits 31:26 and the control bits in 25:0. The decode flag is 1 only in state 32, and state 33 holds condition 01 with jump target 33.
- R3: When the condition selector is 00 and the decode flag is clear, the next state equals the jump target. For example 18→33, 35→32, 1→18 and 15→28.
- R4: Condition 01 ORs `mem_ready` into next-address bit 1. The memory-wait states 16, 17, 25, 28, 29 and 33 therefore stay in place while ready is low, and move to 18, 19, 27, 30, 31 and 35 when it is high.
- R5: Condition 10 ORs `ben_latch` into next-address bit 2. From state 0 the next state is 22 when the latch is set and 18 when it is clear.
- R6: Condition 11 ORs instruction bit 11 (`ir_hi[0]`) into next-address bit 0. From state 4 the next state is 21 when that bit is set and 20 when it is clear.
- R7: In state 32, the decode state, the next state is 00 followed by instruction bits [15:12] (`ir_hi[4:1]`).
- R8: `ben_next` equals (IR[11]&N)|(IR[10]&Z)|(IR[9]&P). Here IR[11] is `ir_hi[0]`, IR[10:9] is `ir_mid[1:0]`, and N, Z, P are `cc_nzp[2]`, `cc_nzp[1]`, `cc_nzp[0]`.
- R9: States 10 and 11 hold an all-zero microinstruction, so their next state is 0.
- R10: Outside reset, every rising edge loads the state register with the `next_state` value shown before that edge.
- R11: State 18 asserts MAR load (bit 25), PC load (bit 19) and PC gate (bit 18). State 33 asserts memory enable (bit 3) with read/write (bit 2) low. State 35 asserts IR load (bit 23) and MDR gate (bit 17).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_ready | input | 1 | Memory access complete |
| ben_latch | input | 1 | Latched branch-enable bit |
| ir_hi | input | 5 | Instruction bits [15:11] |
| ir_mid | input | 2 | Instruction bits [10:9] |
| cc_nzp | input | 3 | Condition codes N, Z, P (bits 2, 1, 0) |
| state_q | output | 6 | Current control state |
| next_state | output | 6 | Address of the state for the next cycle |
| uinst | output | 35 | Microinstruction of the current state |
| ben_next | output | 1 | Branch-enable value for the datapath to latch |

## Verification
`uinst`, `next_state` and `ben_next` are combinational functions of the current state and inputs. They are due in the cycle the inputs are applied. `state_q` takes the new value one rising edge later. The bench drives inputs on the falling edge and samples all outputs shortly after it, well before the next rising edge. It checks `state_q` against the state that its own model predicted at the previous sample, and checks the combinational outputs against the model for the inputs just applied. A reset asserted at a falling edge is expected to show state 18 at the following sample.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int STATE_W   = 6;
    localparam int DEPTH     = 1 << STATE_W;
    localparam int CTRL_W    = 26;
    localparam int OPCODE_W  = 4;
    localparam int UINST_W   = CTRL_W + STATE_W + 2 + 1;

    localparam logic [STATE_W-1:0] FETCH_STATE  = 6'd18;
    localparam logic [STATE_W-1:0] DECODE_STATE = 6'd32;

    typedef enum logic [1:0] {
        COND_ALWAYS = 2'b00,
        COND_READY  = 2'b01,
        COND_BEN    = 2'b10,
        COND_MODE   = 2'b11
    } cond_e;

    localparam logic [1:0] ALU_ADD  = 2'd0;
    localparam logic [1:0] ALU_AND  = 2'd1;
    localparam logic [1:0] ALU_XOR  = 2'd2;

    typedef struct packed {
        logic       ld_mar;
        logic       ld_mdr;
        logic       ld_ir;
        logic       ld_ben;
        logic       ld_reg;
        logic       ld_cc;
        logic       ld_pc;
        logic       gate_pc;
        logic       gate_mdr;
        logic       gate_alu;
        logic       gate_addr;
        logic       gate_shf;
        logic [1:0] pc_sel;
        logic       dr_sel;
        logic       sr1_sel;
        logic       base_sel;
        logic [1:0] off_sel;
        logic       mar_sel;
        logic [1:0] alu_op;
        logic       mem_en;
        logic       mem_wr;
        logic       word_size;
        logic       off_shift;
    } ctrl_t;

    typedef struct packed {
        logic                 ird;
        cond_e                cond;
        logic [STATE_W-1:0]   jump;
        ctrl_t                ctrl;
    } uinst_t;

    // Control-store contents, computed per address.
    function automatic uinst_t ucode_entry(input int unsigned s);
        uinst_t u;
        u = '0;
        case (s)
            0: begin u.cond = COND_BEN; u.jump = 6'd18; end
            1, 5, 9: begin
                u.jump = 6'd18;
                u.ctrl.ld_reg = 1'b1; u.ctrl.ld_cc = 1'b1;
                u.ctrl.gate_alu = 1'b1; u.ctrl.sr1_sel = 1'b1;
                u.ctrl.alu_op = (s == 1) ? ALU_ADD : ((s == 5) ? ALU_AND : ALU_XOR);
            end
            2, 3, 6, 7: begin
                u.jump = (s == 2) ? 6'd29 : ((s == 3) ? 6'd24 : ((s == 6) ? 6'd25 : 6'd23));
                u.ctrl.ld_mar = 1'b1; u.ctrl.gate_addr = 1'b1;
                u.ctrl.base_sel = 1'b1; u.ctrl.off_sel = 2'b01;
                u.ctrl.mar_sel = 1'b1;
                u.ctrl.off_shift = (s == 6 || s == 7);
            end
            4: begin
                u.cond = COND_MODE; u.jump = 6'd20;
                u.ctrl.ld_reg = 1'b1; u.ctrl.dr_sel = 1'b1; u.ctrl.gate_pc = 1'b1;
            end
            8: begin u.jump = 6'd18; end
            12: begin
                u.jump = 6'd18;
                u.ctrl.ld_pc = 1'b1; u.ctrl.pc_sel = 2'b10; u.ctrl.base_sel = 1'b1;
            end
            13: begin
                u.jump = 6'd18;
                u.ctrl.ld_reg = 1'b1; u.ctrl.ld_cc = 1'b1;
                u.ctrl.gate_shf = 1'b1; u.ctrl.sr1_sel = 1'b1;
            end
            14: begin
                u.jump = 6'd18;
                u.ctrl.ld_reg = 1'b1; u.ctrl.ld_cc = 1'b1; u.ctrl.gate_addr = 1'b1;
                u.ctrl.mar_sel = 1'b1; u.ctrl.off_sel = 2'b10; u.ctrl.off_shift = 1'b1;
            end
            15: begin
                u.jump = 6'd28;
                u.ctrl.ld_mar = 1'b1; u.ctrl.gate_addr = 1'b1;
            end
            16, 17: begin
                u.cond = COND_READY; u.jump = s[5:0];
                u.ctrl.mem_en = 1'b1; u.ctrl.mem_wr = 1'b1;
                u.ctrl.word_size = (s == 16);
            end
            18, 19: begin
                u.jump = 6'd33;
                u.ctrl.ld_mar = 1'b1; u.ctrl.ld_pc = 1'b1; u.ctrl.gate_pc = 1'b1;
            end
            20: begin
                u.jump = 6'd18;
                u.ctrl.ld_pc = 1'b1; u.ctrl.pc_sel = 2'b10; u.ctrl.base_sel = 1'b1;
            end
            21, 22: begin
                u.jump = 6'd18;
                u.ctrl.ld_pc = 1'b1; u.ctrl.pc_sel = 2'b10;
                u.ctrl.off_sel = (s == 21) ? 2'b11 : 2'b10; u.ctrl.off_shift = 1'b1;
            end
            23, 24: begin
                u.jump = (s == 23) ? 6'd16 : 6'd17;
                u.ctrl.ld_mdr = 1'b1; u.ctrl.word_size = (s == 23);
            end
            25, 29, 33: begin
                u.cond = COND_READY; u.jump = s[5:0];
                u.ctrl.ld_mdr = 1'b1; u.ctrl.mem_en = 1'b1;
                u.ctrl.word_size = (s != 29);
            end
            27, 31: begin
                u.jump = 6'd18;
                u.ctrl.ld_reg = 1'b1; u.ctrl.ld_cc = 1'b1; u.ctrl.gate_mdr = 1'b1;
                u.ctrl.word_size = (s == 27);
            end
            28: begin
                u.cond = COND_READY; u.jump = 6'd28;
                u.ctrl.ld_mdr = 1'b1; u.ctrl.mem_en = 1'b1; u.ctrl.word_size = 1'b1;
                u.ctrl.ld_reg = 1'b1; u.ctrl.dr_sel = 1'b1; u.ctrl.gate_pc = 1'b1;
            end
            30: begin
                u.jump = 6'd18;
                u.ctrl.ld_pc = 1'b1; u.ctrl.gate_mdr = 1'b1;
                u.ctrl.pc_sel = 2'b01; u.ctrl.word_size = 1'b1;
            end
            32: begin u.ird = 1'b1; u.ctrl.ld_ben = 1'b1; end
            35: begin
                u.jump = 6'd32;
                u.ctrl.ld_ir = 1'b1; u.ctrl.gate_mdr = 1'b1; u.ctrl.word_size = 1'b1;
            end
            default: u = '0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/mseq_ctrl_store.sv
module mseq_ctrl_store
    import mseq_pkg::*;
(
    input  logic [STATE_W-1:0] addr,
    output uinst_t             data
);
    uinst_t rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = ucode_entry(g);
    end

    assign data = rom[addr];

    // R9: the two reserved addresses carry nothing
    always_comb begin
        a_unused_zero_r9: assert (!(addr == 6'd10 || addr == 6'd11) || data == '0);
    end
endmodule

// File: rtl/mseq_branch_eval.sv
module mseq_branch_eval (
    input  logic [2:0] nzp_mask,
    input  logic [2:0] cc_nzp,
    output logic       ben
);
    assign ben = |(nzp_mask & cc_nzp);
endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
    import mseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  uinst_t              ui,
    input  logic                ready,
    input  logic                ben,
    input  logic                mode,
    input  logic [OPCODE_W-1:0] opcode,
    output logic [STATE_W-1:0]  next
);
    logic [STATE_W-1:0] cond_bits;

    always_comb begin
        cond_bits = '0;
        case (ui.cond)
            COND_READY: cond_bits[1] = ready;
            COND_BEN:   cond_bits[2] = ben;
            COND_MODE:  cond_bits[0] = mode;
            default:    cond_bits    = '0;
        endcase
    end

    always_comb begin
        if (ui.ird) next = {{(STATE_W-OPCODE_W){1'b0}}, opcode};
        else        next = ui.jump | cond_bits;
    end

    // R3: with no condition selected the jump target passes unchanged
    p_uncond_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (!ui.ird && ui.cond == COND_ALWAYS) |-> next == ui.jump);

    // R4: a ready condition never alters the other address bits
    p_ready_bits_r4: assert property (@(posedge clk) disable iff (rst)
        (!ui.ird && ui.cond == COND_READY) |-> (next & ~6'b000010) == (ui.jump & ~6'b000010));
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
    import mseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         mem_ready,
    input  logic         ben_latch,
    input  logic [4:0]   ir_hi,
    input  logic [1:0]   ir_mid,
    input  logic [2:0]   cc_nzp,
    output logic [5:0]   state_q,
    output logic [5:0]   next_state,
    output logic [34:0]  uinst,
    output logic         ben_next
);
    uinst_t             cur_ui;
    logic [STATE_W-1:0] state_r;
    logic [STATE_W-1:0] nxt;

    mseq_ctrl_store u_store (
        .addr (state_r),
        .data (cur_ui)
    );

    mseq_next_addr u_next (
        .clk    (clk),
        .rst    (rst),
        .ui     (cur_ui),
        .ready  (mem_ready),
        .ben    (ben_latch),
        .mode   (ir_hi[0]),
        .opcode (ir_hi[4:1]),
        .next   (nxt)
    );

    mseq_branch_eval u_ben (
        .nzp_mask ({ir_hi[0], ir_mid}),
        .cc_nzp   (cc_nzp),
        .ben      (ben_next)
    );

    always_ff @(posedge clk) begin
        if (rst) state_r <= FETCH_STATE;
        else     state_r <= nxt;
    end

    assign state_q    = state_r;
    assign next_state = nxt;
    assign uinst      = cur_ui;

    // R4: a memory wait holds its state while ready is low
    p_mem_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == 6'd33 && !mem_ready) |=> state_q == 6'd33);

    // R10: the register follows the computed next address
    p_advance_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state_q == $past(next_state));

    // R7: decode dispatches on the opcode
    p_decode_r7: assert property (@(posedge clk) disable iff (rst)
        state_q == DECODE_STATE |-> next_state == {2'b00, ir_hi[4:1]});

    // R5: the branch state picks 22 or 18
    p_branch_r5: assert property (@(posedge clk) disable iff (rst)
        state_q == 6'd0 |-> next_state == (ben_latch ? 6'd22 : 6'd18));

    // R9: the reserved states fall through to 0
    p_unused_next_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == 6'd10 || state_q == 6'd11) |-> next_state == 6'd0);
endmodule

// File: tb/mseq_sequencer_tb_top.sv
module mseq_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_ready = 1'b0;
    logic        ben_latch = 1'b0;
    logic [4:0]  ir_hi = '0;
    logic [1:0]  ir_mid = '0;
    logic [2:0]  cc_nzp = '0;
    logic [5:0]  state_q;
    logic [5:0]  next_state;
    logic [34:0] uinst;
    logic        ben_next;

    mseq_sequencer dut_i (
        .clk(clk), .rst(rst), .mem_ready(mem_ready), .ben_latch(ben_latch),
        .ir_hi(ir_hi), .ir_mid(ir_mid), .cc_nzp(cc_nzp),
        .state_q(state_q), .next_state(next_state), .uinst(uinst), .ben_next(ben_next)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int exp_state = 18;
    bit was_reset = 1'b0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (time %0t)", req, act, expv, $time);
        end
    endtask

    function automatic int ref_next(input int s, input bit rdy, input bit ben, input logic [4:0] ir);
        case (s)
            0:  return ben ? 22 : 18;
            2:  return 29;
            3:  return 24;
            4:  return ir[0] ? 21 : 20;
            6:  return 25;
            7:  return 23;
            15: return 28;
            16: return rdy ? 18 : 16;
            17: return rdy ? 19 : 17;
            18, 19: return 33;
            23: return 16;
            24: return 17;
            25: return rdy ? 27 : 25;
            28: return rdy ? 30 : 28;
            29: return rdy ? 31 : 29;
            32: return int'(ir[4:1]);
            33: return rdy ? 35 : 33;
            35: return 32;
            1, 5, 8, 9, 12, 13, 14, 20, 21, 22, 27, 30, 31: return 18;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            0:  return "R5";
            4:  return "R6";
            32: return "R7";
            10, 11: return "R9";
            16, 17, 25, 28, 29, 33: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic step(input bit r, input bit rdy, input bit ben, input logic [4:0] ir,
                        input logic [1:0] mid, input logic [2:0] nzp);
        int e;
        bit eb;
        @(negedge clk);
        rst = r; mem_ready = rdy; ben_latch = ben; ir_hi = ir; ir_mid = mid; cc_nzp = nzp;
        #1;
        if (r) begin
            exp_state = 18;
            was_reset = 1'b1;
        end else begin
            chk(state_q == 6'(exp_state), was_reset ? "R1" : "R10", state_q, exp_state);
            was_reset = 1'b0;
            e = ref_next(exp_state, rdy, ben, ir);
            chk(next_state == 6'(e), tag_of(exp_state), next_state, e);
            chk(uinst[34] == (exp_state == 32), "R2", uinst[34], exp_state == 32);
            if (exp_state == 33) begin
                chk(uinst[33:26] == {2'b01, 6'd33}, "R2", uinst[33:26], {2'b01, 6'd33});
                chk(uinst[3] && !uinst[2], "R11", uinst[3:2], 2'b10);
            end
            if (exp_state == 35)
                chk(uinst[23] && uinst[17], "R11", {uinst[23], uinst[17]}, 2'b11);
            if (exp_state == 18)
                chk(uinst[25] && uinst[19] && uinst[18], "R11",
                    {uinst[25], uinst[19], uinst[18]}, 3'b111);
            if (exp_state == 10 || exp_state == 11)
                chk(uinst == '0, "R9", uinst, 0);
            eb = (ir[0] & nzp[2]) | (mid[1] & nzp[1]) | (mid[0] & nzp[0]);
            chk(ben_next == eb, "R8", ben_next, eb);
            exp_state = e;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        step(1, 0, 0, '0, '0, '0);
        step(1, 0, 0, '0, '0, '0);
        // fetch with memory waits (R4), then decode to opcode 0 (R7)
        step(0, 0, 0, '0, '0, '0);         // 18 -> 33
        step(0, 0, 0, '0, '0, '0);         // 33 holds
        step(0, 0, 0, '0, '0, '0);         // 33 holds
        step(0, 1, 0, '0, '0, '0);         // 33 -> 35
        step(0, 0, 0, '0, '0, '0);         // 35 -> 32
        step(0, 0, 0, 5'b00000, '0, '0);   // 32 -> 0
        step(0, 0, 1, '0, '0, '0);         // 0 -> 22 (R5)
        step(0, 0, 0, '0, '0, '0);         // 22 -> 18
        step(0, 1, 0, '0, '0, '0);         // 18 -> 33
        step(0, 1, 0, '0, '0, '0);         // 33 -> 35
        step(0, 0, 0, '0, '0, '0);         // 35 -> 32
        step(0, 0, 0, 5'b01000, '0, '0);   // 32 -> 4
        step(0, 0, 0, 5'b01000, '0, '0);   // 4 -> 20 (R6)
        step(0, 0, 0, '0, '0, '0);         // 20 -> 18
        step(0, 1, 0, '0, '0, '0);
        step(0, 1, 0, '0, '0, '0);
        step(0, 0, 0, '0, '0, '0);
        step(0, 0, 0, 5'b10100, '0, '0);   // 32 -> 10 (R9)
        step(0, 0, 0, '0, 2'b11, 3'b011);  // 10 -> 0, ben R8
        step(0, 0, 0, 5'b00001, '0, 3'b100); // 0 -> 18, ben via IR[11]&N
        // random stimulus with occasional reset
        for (int i = 0; i < 6000; i++) begin
            step(($urandom % 400) == 0, ($urandom % 3) == 0, $urandom % 2,
                 5'($urandom), 2'($urandom), 3'($urandom));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule